// File: doc/BRIEF.md
# Serial ADC Control Frame Interface

This block is the digital serial front end of a four-channel, 12-bit converter model. It acts as a serial-peripheral slave with an active-low chip select, a serial clock that idles low, a data input and a data output. It oversamples all three serial lines in the system clock domain. Every chip-select frame lasts 16 serial clocks. During a frame the block takes in a 12-bit control word, MSB first, on falling serial clock edges. At the same time it shifts out the result of the previous conversion, with that result's channel address ahead of the data.

The analog conversion is modelled by a parallel raw sample in straight binary, `sample_i`. The block captures it when chip select falls. It formats the sample as twos complement or straight binary, according to the coding bit held at that moment. A write therefore takes effect on the conversion after the frame that carries it. The channel for the next conversion is taken from the control register on the 14th falling edge. The range, power-mode and sequencer fields are brought out as registered outputs. The sequencer fields are stored and brought out only; this block does not step through channels.

Top module: `adc_frame_if`

## Requirements
- R1: Within a frame, input bits are taken on falling serial clock edges, MSB first. After the 12th falling edge, if the first bit (bit 11) was 1, the control register loads from the word, where bit 11 is the write flag. The fields are: seq1 = bit 10, address = bits 7:6, power mode = bits 5:4, seq0 = bit 3, range = bit 1, coding = bit 0. Bits 9, 8 and 2 are unused. `seq_o` = {seq1, seq0}.
- R2: A word whose bit 11 is 0 leaves every control register output unchanged.
- R3: Data input values on falling edges 13 to 16 have no effect on the control register.
- R4: If chip select rises before the 12th falling edge, the control register keeps its previous value, even when the word's write bit was 1.
- R5: The output frame is 16 bits, MSB first: two zeros, then the 2-bit channel address of the result, then 12 data bits. The first bit is present once chip select falls, and each following bit changes after a falling edge, so the host samples on rising edges.
- R6: When coding is 0, the data equals the raw sample with its MSB inverted (twos complement). When coding is 1, the data equals the raw sample unchanged. The coding used is the value held when chip select falls, so a write affects only later frames.
- R7: On the 14th falling edge, `chan_o` takes the control register's address field. The next frame reports that channel. A frame ended after 13 edges leaves `chan_o` unchanged.
- R8: `dout_oe_o` is 0 while chip select is high and 1 during a frame. After the 16th falling edge, `dout_o` is 0.
- R9: After reset: address 0, power mode 2'b11, sequencer 2'b00, range 0, coding 0, `chan_o` 0, output disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select framing a transfer |
| sclk_i | input | 1 | Serial clock, idle low |
| din_i | input | 1 | Serial control data, taken on falling edges |
| sample_i | input | 12 | Raw conversion sample, straight binary |
| dout_o | output | 1 | Serial result data |
| dout_oe_o | output | 1 | Output enable for dout_o, low models high impedance |
| chan_o | output | 2 | Channel selected for the next conversion |
| pm_o | output | 2 | Power-mode field of the control register |
| seq_o | output | 2 | Sequencer field {seq1, seq0} |
| range_o | output | 1 | Input range select for the next conversion |
| coding_o | output | 1 | Output coding select, 1 = straight binary |

## Verification
The assertions check four rules on every cycle. Control fields may change only on the step from the 11th to the 12th edge, and the channel only on the 14th. The data output may move only right after a falling edge or a frame start. The output stays disabled while chip select is high and reads zero once all 16 edges have passed. The exact content of a frame, the two coding formats, the one-frame delay of coding and channel changes, and the ignoring of aborted frames and tail bits can only be shown by the bench's scenarios, which compare whole frames against a model.

// File: rtl/adc_if_pkg.sv
package adc_if_pkg;
  localparam int CTRL_W    = 12;
  localparam int ADDR_W    = 2;
  localparam int WR_BIT    = 11;
  localparam int SEQ1_BIT  = 10;
  localparam int ADD_LO    = 6;
  localparam int PM_LO     = 4;
  localparam int SEQ0_BIT  = 3;
  localparam int RANGE_BIT = 1;
  localparam int CODE_BIT  = 0;

  typedef struct packed {
    logic [1:0]        seq;
    logic [ADDR_W-1:0] add;
    logic [1:0]        pm;
    logic              rng;
    logic              code;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{seq: 2'b00, add: '0, pm: 2'b11, rng: 1'b0, code: 1'b0};

  function automatic ctrl_t decode_word(logic [CTRL_W-1:0] w);
    ctrl_t c;
    c.seq  = {w[SEQ1_BIT], w[SEQ0_BIT]};
    c.add  = w[ADD_LO +: ADDR_W];
    c.pm   = w[PM_LO +: 2];
    c.rng  = w[RANGE_BIT];
    c.code = w[CODE_BIT];
    return c;
  endfunction
endpackage

// File: rtl/adc_if_sync.sv
module adc_if_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic din_i,
  output logic cs_o,
  output logic din_o,
  output logic sclk_fall_o,
  output logic cs_fall_o
);
  localparam int N = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [N-1:0] cs_q, sclk_q, din_q;
  logic         sclk_d, cs_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= '1;
      sclk_q <= '0;
      din_q  <= '0;
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      cs_q   <= {cs_q[N-2:0], cs_ni};
      sclk_q <= {sclk_q[N-2:0], sclk_i};
      din_q  <= {din_q[N-2:0], din_i};
      sclk_d <= sclk_q[N-1];
      cs_d   <= cs_q[N-1];
    end
  end

  assign cs_o        = cs_q[N-1];
  assign din_o       = din_q[N-1];
  // falling edges count only inside a frame
  assign sclk_fall_o = sclk_d & ~sclk_q[N-1] & ~cs_q[N-1];
  assign cs_fall_o   = cs_d & ~cs_q[N-1];
endmodule

// File: rtl/adc_if_rx.sv
module adc_if_rx
  import adc_if_pkg::*;
#(
  parameter int FRAME_LEN = 16,
  parameter int CHAN_EDGE = 14,
  localparam int CNT_W    = $clog2(FRAME_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              din_i,
  input  logic              fall_i,
  input  logic              cs_fall_i,
  output ctrl_t             ctrl_o,
  output logic [ADDR_W-1:0] chan_o,
  output logic [CNT_W-1:0]  edge_cnt_o
);
  localparam logic [CNT_W-1:0] LOAD_AT = CNT_W'(CTRL_W);
  localparam logic [CNT_W-1:0] CHAN_AT = CNT_W'(CHAN_EDGE);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(FRAME_LEN);

  logic [CNT_W-1:0]  cnt, cnt_nxt;
  logic [CTRL_W-1:0] sh, word_nxt;
  logic              step;

  assign step     = fall_i && (cnt < LAST);
  assign cnt_nxt  = cnt + 1'b1;
  assign word_nxt = {sh[CTRL_W-2:0], din_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt    <= LAST;
      sh     <= '0;
      ctrl_o <= CTRL_RST;
      chan_o <= '0;
    end else if (cs_fall_i) begin
      cnt <= '0;
      sh  <= '0;
    end else if (step) begin
      cnt <= cnt_nxt;
      if (cnt < LOAD_AT) sh <= word_nxt;
      if (cnt_nxt == LOAD_AT && word_nxt[WR_BIT]) ctrl_o <= decode_word(word_nxt);
      if (cnt_nxt == CHAN_AT) chan_o <= ctrl_o.add;
    end
  end

  assign edge_cnt_o = cnt;
endmodule

// File: rtl/adc_if_tx.sv
module adc_if_tx
  import adc_if_pkg::*;
#(
  parameter int FRAME_LEN = 16,
  parameter int DATA_W    = 12,
  localparam int PAD_W    = FRAME_LEN - ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              fall_i,
  input  logic              cs_fall_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [ADDR_W-1:0] chan_i,
  input  logic              code_i,
  output logic              dout_o,
  output logic              dout_oe_o
);
  logic [FRAME_LEN-1:0] sr;
  logic [DATA_W-1:0]    coded;

  // straight binary to twos complement: flip the MSB
  assign coded = code_i ? sample_i : {~sample_i[DATA_W-1], sample_i[DATA_W-2:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sr <= '0;
    else if (cs_fall_i) sr <= {{PAD_W{1'b0}}, chan_i, coded};
    else if (fall_i)    sr <= {sr[FRAME_LEN-2:0], 1'b0};
  end

  assign dout_o    = sr[FRAME_LEN-1];
  assign dout_oe_o = ~cs_i;
endmodule

// File: rtl/adc_frame_if.sv
module adc_frame_if
  import adc_if_pkg::*;
#(
  parameter int FRAME_LEN   = 16,
  parameter int CHAN_EDGE   = 14,
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(FRAME_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic [ADDR_W-1:0] chan_o,
  output logic [1:0]        pm_o,
  output logic [1:0]        seq_o,
  output logic              range_o,
  output logic              coding_o
);
  logic             cs_s, din_s, sclk_fall, cs_fall;
  logic [CNT_W-1:0] edge_cnt;
  ctrl_t            ctrl;

  adc_if_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .cs_ni, .sclk_i, .din_i,
    .cs_o(cs_s), .din_o(din_s), .sclk_fall_o(sclk_fall), .cs_fall_o(cs_fall)
  );

  adc_if_rx #(.FRAME_LEN(FRAME_LEN), .CHAN_EDGE(CHAN_EDGE)) u_rx (
    .clk_i, .rst_ni, .din_i(din_s), .fall_i(sclk_fall), .cs_fall_i(cs_fall),
    .ctrl_o(ctrl), .chan_o(chan_o), .edge_cnt_o(edge_cnt)
  );

  adc_if_tx #(.FRAME_LEN(FRAME_LEN), .DATA_W(DATA_W)) u_tx (
    .clk_i, .rst_ni, .cs_i(cs_s), .fall_i(sclk_fall), .cs_fall_i(cs_fall),
    .sample_i, .chan_i(chan_o), .code_i(ctrl.code),
    .dout_o, .dout_oe_o
  );

  assign pm_o     = ctrl.pm;
  assign seq_o    = ctrl.seq;
  assign range_o  = ctrl.rng;
  assign coding_o = ctrl.code;
endmodule

// File: rtl/adc_frame_if_chk.sv
module adc_frame_if_chk #(
  parameter int FRAME_LEN = 16,
  parameter int CHAN_EDGE = 14,
  parameter int CNT_W     = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic             dout_o,
  input logic             dout_oe_o,
  input logic [1:0]       chan_o,
  input logic [1:0]       pm_o,
  input logic [1:0]       seq_o,
  input logic             range_o,
  input logic             coding_o,
  input logic [CNT_W-1:0] edge_cnt,
  input logic             sclk_fall,
  input logic             cs_fall
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] LDAT = CNT_W'(12);
  localparam logic [CNT_W-1:0] CHAT = CNT_W'(CHAN_EDGE);

  // R1 R2 R4: control fields move only on the 11 -> 12 edge step
  a_r1_ctrl_change_at_edge12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({seq_o, pm_o, range_o, coding_o}) |-> (edge_cnt == LDAT && $past(edge_cnt) == LDAT - 1'b1));

  // R7
  a_r7_chan_change_at_edge14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(chan_o) |-> (edge_cnt == CHAT && $past(edge_cnt) == CHAT - 1'b1));

  // R5
  a_r5_dout_moves_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(dout_o) && dout_oe_o && $past(dout_oe_o)) |-> ($past(sclk_fall) || $past(cs_fall)));

  // R8: covers synchronizer depths up to 3
  a_r8_oe_off_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3)) |-> !dout_oe_o);

  // R8
  a_r8_zero_after_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_cnt == LAST) |-> !dout_o);
endmodule

bind adc_frame_if adc_frame_if_chk #(.FRAME_LEN(FRAME_LEN), .CHAN_EDGE(CHAN_EDGE), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .dout_o(dout_o), .dout_oe_o(dout_oe_o),
  .chan_o(chan_o), .pm_o(pm_o), .seq_o(seq_o), .range_o(range_o), .coding_o(coding_o),
  .edge_cnt(edge_cnt), .sclk_fall(sclk_fall), .cs_fall(cs_fall)
);

// File: tb/adc_frame_if_tb_top.sv
`timescale 1ns/1ps
module adc_frame_if_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1;
  logic        sclk_i = 1'b0;
  logic        din_i = 1'b0;
  logic [11:0] sample_i = '0;
  logic        dout_o, dout_oe_o, range_o, coding_o;
  logic [1:0]  chan_o, pm_o, seq_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] exp_q[$];

  // model state
  logic [1:0] m_seq = 2'b00, m_add = 2'b00, m_pm = 2'b11, m_chan = 2'b00;
  logic       m_rng = 1'b0, m_code = 1'b0;

  always #2.5 clk_i = ~clk_i;

  adc_frame_if dut_i (
    .clk_i, .rst_ni, .cs_ni, .sclk_i, .din_i, .sample_i,
    .dout_o, .dout_oe_o, .chan_o, .pm_o, .seq_o, .range_o, .coding_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] mk(input logic wr, input logic s1, input logic [1:0] add,
                                     input logic [1:0] pm, input logic s0, input logic rng,
                                     input logic code);
    return {wr, s1, 2'b00, add, pm, s0, 1'b0, rng, code};
  endfunction

  // driver: one frame of n falling edges; tail drives edges 13..16
  task automatic run_frame(input logic [11:0] w, input int n, input logic [11:0] smp,
                           input logic [3:0] tail);
    logic [15:0] bits;
    bits = {w, tail};
    if (n == 16)
      exp_q.push_back({2'b00, m_chan, m_code ? smp : {~smp[11], smp[10:0]}});
    sample_i = smp;
    cs_ni = 1'b0;
    #40;
    for (int i = 0; i < n; i++) begin
      sclk_i = 1'b1;
      din_i  = bits[15-i];
      #40;
      sclk_i = 1'b0;
      #40;
    end
    cs_ni = 1'b1;
    #100;
    if (n >= 12 && w[11]) begin
      m_seq = {w[10], w[3]}; m_add = w[7:6]; m_pm = w[5:4]; m_rng = w[1]; m_code = w[0];
    end
    if (n >= 14) m_chan = m_add;
  endtask

  task automatic check_regs(input string tag);
    check({"R1 R2 R4 range ", tag}, range_o, m_rng);
    check({"R1 R2 R4 pm ", tag}, pm_o, m_pm);
    check({"R1 R3 seq ", tag}, seq_o, m_seq);
    check({"R6 coding ", tag}, coding_o, m_code);
    check({"R7 chan ", tag}, chan_o, m_chan);
    check({"R8 oe idle ", tag}, dout_oe_o, 1'b0);
  endtask

  // monitor: collect bits on rising edges, compare at frame end
  initial begin
    logic [15:0] got;
    int nb;
    got = '0; nb = 0;
    forever begin
      @(posedge sclk_i or posedge cs_ni);
      if (cs_ni) begin
        if (nb == 16) begin
          if (exp_q.size() == 0) check("R5 unexpected frame", 32'(got), 32'hFFFF_FFFF);
          else check("R5 R6 R7 frame", 32'(got), 32'(exp_q.pop_front()));
        end
        nb = 0;
      end else begin
        #1;
        check("R8 oe in frame", dout_oe_o, 1'b1);
        got = {got[14:0], dout_o};
        nb++;
      end
    end
  end

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #23 rst_ni = 1'b1;
    #50;
    // R9 reset state
    check("R9 range", range_o, 1'b0);
    check("R9 pm", pm_o, 2'b11);
    check("R9 seq", seq_o, 2'b00);
    check("R9 coding", coding_o, 1'b0);
    check("R9 chan", chan_o, 2'b00);
    check("R9 oe", dout_oe_o, 1'b0);

    run_frame(mk(1, 0, 2'd2, 2'b11, 0, 1, 1), 16, 12'h123, 4'h0);  // R1 write
    check_regs("f1");
    run_frame(12'h7FF, 16, 12'hABC, 4'h0);                        // R2 no write
    check_regs("f2");
    run_frame(12'hFFF, 8, 12'h555, 4'h0);                         // R4 abort
    check_regs("f3");
    run_frame(mk(1, 1, 2'd3, 2'b10, 1, 0, 0), 16, 12'h000, 4'hF);  // R3 tail ones
    check_regs("f4");
    run_frame(12'h000, 16, 12'hFFF, 4'h0);                        // R6 twos complement
    check_regs("f5");
    run_frame(mk(1, 0, 2'd1, 2'b01, 0, 1, 0), 13, 12'h321, 4'h0);  // R7 ends before 14
    check_regs("f6");
    run_frame(12'h000, 16, 12'h800, 4'h0);                        // R7 latch on 14
    check_regs("f7");
    run_frame(mk(1, 0, 2'd0, 2'b11, 0, 0, 1), 16, 12'h7F0, 4'h0);
    check_regs("f8");
    run_frame(12'h000, 16, 12'h7F0, 4'h0);                        // R6 straight
    check_regs("f9");

    check("R5 all frames seen", exp_q.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule